// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the control word of a clock synthesizer: a 9-bit feedback divider value M, a 3-bit output divider code N and a 2-bit test-select field T. The word can come from two places. The first is a set of parallel pins governed by a parallel strobe. The second is a three-wire serial port made of a serial clock, serial data and a serial load strobe. All four asynchronous control inputs are brought into the system clock domain through two-flop synchronizers, and edges are taken from the synchronized copies.

While the parallel strobe is low, the parallel pins flow through to the active M and N values. When the strobe rises, the values in place at that moment are held. With the strobe high, the serial port shifts a 14-bit frame in. A rising serial load strobe commits the frame to M, N and T. Holding the load strobe high commits the register contents on every serial clock. A multiplexed TEST pin, selected by T, exposes the serial data, the feedback divider output or a CMOS copy of the output clock. A status flag marks M values that the loop cannot lock to.

Top module: `synth_cfg_loader`

## Requirements
- R1: While the synchronized parallel strobe is low, m_o and n_o take par_m_i and par_n_i on every clock, one cycle after the pins change.
- R2: Once the parallel strobe is high, changes on par_m_i and par_n_i have no effect on m_o and n_o.
- R3: With the parallel strobe high, each rising serial clock edge shifts ser_dat_i into a 14-bit register, MSB first. After 14 bits the register holds T1 in bit 13, T0 in bit 12, N in bits 11:9 (N2 first) and M in bits 8:0 (M8 first, M0 last).
- R4: A rising edge of the serial load strobe while the parallel strobe is high copies the register to the outputs: bits 13:12 to t_o, bits 11:9 to n_o and bits 8:0 to m_o.
- R5: After the serial load strobe falls, further serial clocks leave m_o, n_o and t_o unchanged.
- R6: While the serial load strobe is high, each rising serial clock edge shifts the register and copies the shifted contents to t_o, n_o and m_o.
- R7: A serial transfer replaces values held by a parallel capture, and when the parallel strobe returns low, M and N follow the pins again while t_o keeps its value.
- R8: With the parallel strobe high, test_o follows t_o: 2'b00 gives 0, 2'b01 gives the synchronized serial data, 2'b10 gives mdiv_mon_i and 2'b11 gives fout_mon_i.
- R9: test_o is 0 whenever the synchronized parallel strobe is low, regardless of t_o.
- R10: m_invalid_o is 1 exactly when m_o is below 125 or above 350, and 0 for 125 through 350.
- R11: Reset sets t_o to 2'b00. On the first clock after reset is released, m_o and n_o take the pin values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_m_i | input | 9 | Parallel M value |
| par_n_i | input | 3 | Parallel N code |
| par_strobe_i | input | 1 | Parallel strobe: low passes pins through, high holds them |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_ld_i | input | 1 | Serial load strobe (asynchronous) |
| mdiv_mon_i | input | 1 | Feedback divider output for TEST |
| fout_mon_i | input | 1 | CMOS output clock copy for TEST |
| m_o | output | 9 | Active M value |
| n_o | output | 3 | Active N code |
| t_o | output | 2 | Active test-select bits |
| test_o | output | 1 | Multiplexed test output |
| m_invalid_o | output | 1 | Active M outside 125..350 |

## Verification
A change on a control input is due on the outputs at the third clock edge after it, because it crosses two synchronizer flops and an edge-detect flop. Parallel pin data is due one edge after it changes while the strobe is low. The TEST selection of a monitor input is combinational. The serial-data selection follows the second synchronizer flop. The bench changes inputs on falling clock edges, waits at least four cycles after any control step and samples on a falling edge, so every check lands after the latest due cycle.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W      = 9;
  localparam int N_W      = 3;
  localparam int T_W      = 2;
  localparam int FRAME_W  = T_W + N_W + M_W;
  localparam int M_MIN    = 125;
  localparam int M_MAX    = 350;
  localparam int SYNC_STG = 2;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign sr_o = sr_q;

  assert_sr_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import synth_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_mode_i,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           xfer_i,
  input  cfg_t           xfer_val_i,
  output cfg_t           cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (par_mode_i) begin
      cfg_q.m <= par_m_i;
      cfg_q.n <= par_n_i;
    end else if (xfer_i) begin
      cfg_q <= xfer_val_i;
    end
  end

  assign cfg_o = cfg_q;

  assert_par_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(par_mode_i)) |-> (cfg_q.m == $past(par_m_i) && cfg_q.n == $past(par_n_i)));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_mode_i && !xfer_i) |=> $stable(cfg_q));

  assert_t_only_serial_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(cfg_q.t));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] par_m_i,
  input  logic [N_W-1:0] par_n_i,
  input  logic           par_strobe_i,
  input  logic           ser_clk_i,
  input  logic           ser_dat_i,
  input  logic           ser_ld_i,
  input  logic           mdiv_mon_i,
  input  logic           fout_mon_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           test_o,
  output logic           m_invalid_o
);
  logic [3:0]         sync_q;
  logic               strobe_s, sclk_s, sdat_s, sld_s;
  logic               sclk_d, sld_d;
  logic               sclk_rise, sld_rise, shift_en, xfer;
  logic [FRAME_W-1:0] sr;
  cfg_t               xfer_val, cfg;

  cfg_sync #(.W(4), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({par_strobe_i, ser_clk_i, ser_dat_i, ser_ld_i}),
    .q_o   (sync_q)
  );
  assign {strobe_s, sclk_s, sdat_s, sld_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      sld_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sld_d  <= sld_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sld_rise  = sld_s & ~sld_d;
  assign shift_en  = strobe_s & sclk_rise;
  // load high: each shift commits the freshly shifted word
  assign xfer      = strobe_s & (sld_rise | (sld_s & sclk_rise));
  assign xfer_val  = (sld_s & sclk_rise) ? cfg_t'({sr[FRAME_W-2:0], sdat_s}) : cfg_t'(sr);

  cfg_shift #(.W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_en),
    .bit_i  (sdat_s),
    .sr_o   (sr)
  );

  cfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_mode_i(~strobe_s),
    .par_m_i   (par_m_i),
    .par_n_i   (par_n_i),
    .xfer_i    (xfer),
    .xfer_val_i(xfer_val),
    .cfg_o     (cfg)
  );

  assign m_o = cfg.m;
  assign n_o = cfg.n;
  assign t_o = cfg.t;

  always_comb begin
    test_o = 1'b0;
    if (strobe_s) begin
      unique case (cfg.t)
        2'b00:   test_o = 1'b0;
        2'b01:   test_o = sdat_s;
        2'b10:   test_o = mdiv_mon_i;
        default: test_o = fout_mon_i;
      endcase
    end
  end

  assign m_invalid_o = (cfg.m < M_W'(M_MIN)) || (cfg.m > M_W'(M_MAX));

  assert_test_par_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_s |-> !test_o);

  assert_load_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_s && sld_rise && !sclk_rise) |=> (cfg == cfg_t'($past(sr))));

  assert_range_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.m == M_W'(M_MIN) || cfg.m == M_W'(M_MAX)) |-> !m_invalid_o);
endmodule

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] par_m = 9'd100;
  logic [2:0] par_n = 3'd5;
  logic       par_strobe = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic       mdiv_mon = 1'b0, fout_mon = 1'b0;
  logic [8:0] m;
  logic [2:0] n;
  logic [1:0] t;
  logic       test, m_inv;

  int checks = 0;
  int failures = 0;
  logic [13:0] exp_sr = '0;

  always #10 clk = ~clk;

  synth_cfg_loader u_synth_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .par_m_i(par_m), .par_n_i(par_n),
    .par_strobe_i(par_strobe), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_ld_i(ser_ld), .mdiv_mon_i(mdiv_mon), .fout_mon_i(fout_mon),
    .m_o(m), .n_o(n), .t_o(t), .test_o(test), .m_invalid_o(m_inv)
  );

  // {inv, t[1:0], n[2:0], m[8:0]}
  localparam logic [14:0] VECS [8] = '{
    {1'b0, 2'b00, 3'd3, 9'd200},
    {1'b1, 2'b01, 3'd6, 9'd124},
    {1'b0, 2'b10, 3'd1, 9'd125},
    {1'b0, 2'b11, 3'd7, 9'd350},
    {1'b1, 2'b00, 3'd0, 9'd351},
    {1'b1, 2'b10, 3'd2, 9'd0},
    {1'b1, 2'b01, 3'd4, 9'd511},
    {1'b0, 2'b00, 3'd5, 9'd258}
  };

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b;
    wait_cyc(4);
    ser_clk = 1'b1;
    if (par_strobe) exp_sr = {exp_sr[12:0], b};
    wait_cyc(4);
    ser_clk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) ser_bit(f[i]);
  endtask

  task automatic pulse_ld();
    ser_ld = 1'b1;
    wait_cyc(5);
    ser_ld = 1'b0;
    wait_cyc(5);
  endtask

  task automatic check_cfg(input string req, input logic [13:0] f);
    check(req, {t, n, m}, f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R11 reset: T cleared, pins loaded
    check("R11 m", m, 9'd100);
    check("R11 n", n, 3'd5);
    check("R11 t", t, 2'b00);
    check("R10 inv 100", m_inv, 1'b1);
    check("R9 test low", test, 1'b0);

    par_m = 9'd300; par_n = 3'd2;
    wait_cyc(1);
    check("R1 follow m", m, 9'd300);
    check("R1 follow n", n, 3'd2);
    check("R10 valid 300", m_inv, 1'b0);

    par_strobe = 1'b1;
    wait_cyc(5);
    par_m = 9'd7; par_n = 3'd6;
    wait_cyc(4);
    check("R2 held m", m, 9'd300);
    check("R2 held n", n, 3'd2);

    for (int i = 0; i < 8; i++) begin
      send_frame(VECS[i][13:0]);
      check("R3 no commit before load", {t, n, m}, (i == 0) ? {2'b00, 3'd2, 9'd300} : VECS[i-1][13:0]);
      pulse_ld();
      check_cfg("R4 R3 frame", VECS[i][13:0]);
      check("R10 range", m_inv, VECS[i][14]);
    end

    // R5: bits after load falls do not commit
    ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
    check_cfg("R5 hold", VECS[7][13:0]);

    // R6: load held high, each clock commits shifted word
    ser_ld = 1'b1;
    wait_cyc(5);
    check_cfg("R6 load rise", exp_sr);
    begin
      logic [13:0] f6;
      f6 = {2'b10, 3'd3, 9'd129};
      ser_bit(f6[13]);
      check_cfg("R6 first bit", exp_sr);
      for (int i = 12; i >= 0; i--) ser_bit(f6[i]);
      check_cfg("R6 full frame", f6);
    end
    ser_ld = 1'b0;
    wait_cyc(5);

    // R8: TEST selection
    send_frame({2'b00, 3'd1, 9'd200}); pulse_ld();
    mdiv_mon = 1'b1; fout_mon = 1'b1; ser_dat = 1'b1;
    wait_cyc(4);
    check("R8 sel00", test, 1'b0);
    send_frame({2'b01, 3'd1, 9'd200}); pulse_ld();
    ser_dat = 1'b1; wait_cyc(4);
    check("R8 sel01 hi", test, 1'b1);
    ser_dat = 1'b0; wait_cyc(4);
    check("R8 sel01 lo", test, 1'b0);
    send_frame({2'b10, 3'd1, 9'd200}); pulse_ld();
    mdiv_mon = 1'b1; fout_mon = 1'b0; #1;
    check("R8 sel10 hi", test, 1'b1);
    mdiv_mon = 1'b0; fout_mon = 1'b1; #1;
    check("R8 sel10 lo", test, 1'b0);
    send_frame({2'b11, 3'd1, 9'd200}); pulse_ld();
    fout_mon = 1'b1; mdiv_mon = 1'b0; #1;
    check("R8 sel11 hi", test, 1'b1);
    fout_mon = 1'b0; mdiv_mon = 1'b1; #1;
    check("R8 sel11 lo", test, 1'b0);

    // R7 / R9: back to parallel, then serial override of a capture
    fout_mon = 1'b1;
    par_m = 9'd150; par_n = 3'd4;
    par_strobe = 1'b0;
    wait_cyc(5);
    check("R7 pins again m", m, 9'd150);
    check("R7 t kept", t, 2'b11);
    check("R9 test low par", test, 1'b0);
    par_strobe = 1'b1;
    wait_cyc(5);
    check("R7 captured", m, 9'd150);
    send_frame({2'b00, 3'd6, 9'd340}); pulse_ld();
    check_cfg("R7 override", {2'b00, 3'd6, 9'd340});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule